// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Bank

This block is a byte-wide register slave on a peripheral bus with sixteen register slots. The slot is picked by a four-bit index taken from the host address; all other address bits are ignored. It owns the interrupt state of the peripheral: a flag register and an enable register. From these it drives one level interrupt line, which can be raised by two sources: the shift-register source and the timer-1 source.

Neighbouring logic (timers and the shift/handshake engine) raises flags through one-cycle strobes and presents its count, latch and shift values on read ports. The bank returns those values on reads, and reading the shift value or either byte of the timer-1 count acknowledges the matching flag as a side effect. Software clears flags by writing ones to the flag register, and it changes enables with a write whose bit 7 selects between setting and clearing. Both port data registers, both direction registers, the auxiliary and peripheral control registers and the no-handshake port register are plain read/write storage.

Top module: `intr_regbank`

## Requirements
- R1: The register index is bus_addr[12:9], and no other address bit has an effect. On reads, index 0 returns port B, 1 port A, 2 direction B, 3 direction A, 4/5 the low/high byte of t1_count, 6/7 the low/high byte of t1_latch, 8/9 the low/high byte of t2_count, 10 shift_value, 11 auxiliary control, 12 peripheral control, 13 flags, 14 enables and 15 the no-handshake port.
- R2: Indices 0, 1, 2, 3, 11, 12 and 15 are independent 8-bit storage registers. Each reads back the last value written to it and is 0 after reset.
- R3: A shift_set pulse sets flag bit 2 and a t1_set pulse sets flag bit 6. No flag bit becomes set without its strobe.
- R4: A write to index 13 clears each flag bit whose written bit is 1. All other flag bits keep their value.
- R5: A write to index 14 with bit 7 = 1 ORs data bits 6:0 into the enables. With bit 7 = 0, each enable written as 1 is cleared and the others are kept.
- R6: irq is high exactly when (flags AND enables AND 0x44) is nonzero. It follows the registered state in the cycle after any change.
- R7: A read of index 10 clears flag bit 2, and a read of index 4 or 5 clears flag bit 6. Reads of other indices leave the flags unchanged.
- R8: After reset the enables read 0x44, the flags read 0x00 and irq is low.
- R9: If a set strobe and a clearing access (a flag write or a side-effect read) hit the same flag bit in the same cycle, the flag ends up set.
- R10: Reads of the flag and enable registers return 0 in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Host address; bits 12:9 select the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| shift_set | input | 1 | One-cycle strobe raising the shift flag |
| t1_set | input | 1 | One-cycle strobe raising the timer-1 flag |
| t1_count | input | 16 | Current timer-1 count |
| t1_latch | input | 16 | Timer-1 reload latch |
| t2_count | input | 16 | Current timer-2 count |
| shift_value | input | 8 | Current shift-register content |
| irq | output | 1 | Level interrupt request |

## Verification
The flag logic is driven with each strobe alone, with both strobes together, and with each strobe in the same cycle as a clearing write or a side-effect read. This separates plain set/clear behaviour from the set-wins priority. Enable writes cover set mode, clear mode, all-ones and a mixed clear pattern, and irq is observed with a flag raised while its enable is off and again after the enable is turned on. This distinguishes gating by enable from gating by flag. Every index is read through an address whose other bits are nonzero, with a distinct byte in each register, so a swapped or mis-decoded slot shows up as a wrong value.

// File: rtl/intr_regbank_pkg.sv
package intr_regbank_pkg;

    localparam int BYTE_W   = 8;
    localparam int FLAG_W   = 7;
    localparam int SR_BIT   = 2;
    localparam int T1_BIT   = 6;
    localparam int MODE_BIT = 7;
    localparam int N_PLAIN  = 7;
    localparam logic [FLAG_W-1:0] SRC_MASK = 7'h44;
    localparam logic [FLAG_W-1:0] EN_RST   = 7'h44;

    typedef enum logic [3:0] {
        IX_PORTB   = 4'd0,
        IX_PORTA   = 4'd1,
        IX_DIRB    = 4'd2,
        IX_DIRA    = 4'd3,
        IX_T1C_LO  = 4'd4,
        IX_T1C_HI  = 4'd5,
        IX_T1L_LO  = 4'd6,
        IX_T1L_HI  = 4'd7,
        IX_T2C_LO  = 4'd8,
        IX_T2C_HI  = 4'd9,
        IX_SHIFT   = 4'd10,
        IX_AUX     = 4'd11,
        IX_PCTL    = 4'd12,
        IX_FLAGS   = 4'd13,
        IX_ENABLES = 4'd14,
        IX_PA_NOHS = 4'd15
    } reg_idx_e;

    // Storage slot for a plain register index, or -1 when the index is not plain.
    function automatic int plain_slot(reg_idx_e ix);
        case (ix)
            IX_PORTB:   return 0;
            IX_PORTA:   return 1;
            IX_DIRB:    return 2;
            IX_DIRA:    return 3;
            IX_AUX:     return 4;
            IX_PCTL:    return 5;
            IX_PA_NOHS: return 6;
            default:    return -1;
        endcase
    endfunction

    typedef struct packed {
        logic [N_PLAIN-1:0] plain_we;
        logic               flag_we;
        logic               en_we;
        logic               clr_sr;
        logic               clr_t1;
    } dec_t;

endpackage

// File: rtl/intr_regbank_decode.sv
module intr_regbank_decode
    import intr_regbank_pkg::*;
(
    input  logic     acc,
    input  logic     wr,
    input  reg_idx_e idx,
    output dec_t     dec
);

    always_comb begin
        dec = '0;
        if (acc && wr) begin
            dec.flag_we = (idx == IX_FLAGS);
            dec.en_we   = (idx == IX_ENABLES);
            for (int s = 0; s < N_PLAIN; s++) begin
                dec.plain_we[s] = (plain_slot(idx) == s);
            end
        end
        if (acc && !wr) begin
            dec.clr_sr = (idx == IX_SHIFT);
            dec.clr_t1 = (idx == IX_T1C_LO) || (idx == IX_T1C_HI);
        end
    end

endmodule

// File: rtl/intr_regbank_flags.sv
module intr_regbank_flags
    import intr_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_sr,
    input  logic              set_t1,
    input  logic              flag_we,
    input  logic              en_we,
    input  logic              clr_sr,
    input  logic              clr_t1,
    input  logic [BYTE_W-1:0] wdata,
    output logic [FLAG_W-1:0] flags,
    output logic [FLAG_W-1:0] enables,
    output logic              irq
);

    typedef struct packed {
        logic [FLAG_W-1:0] flg;
        logic [FLAG_W-1:0] en;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [FLAG_W-1:0] clr_v;
        logic [FLAG_W-1:0] set_v;
        clr_v = '0;
        set_v = '0;
        if (flag_we) clr_v = wdata[FLAG_W-1:0];
        if (clr_sr)  clr_v[SR_BIT] = 1'b1;
        if (clr_t1)  clr_v[T1_BIT] = 1'b1;
        set_v[SR_BIT] = set_sr;
        set_v[T1_BIT] = set_t1;

        st_d     = st_q;
        st_d.flg = (st_q.flg & ~clr_v) | set_v;
        if (en_we) begin
            if (wdata[MODE_BIT]) st_d.en = st_q.en | wdata[FLAG_W-1:0];
            else                 st_d.en = st_q.en & ~wdata[FLAG_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flg <= '0;
            st_q.en  <= EN_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags   = st_q.flg;
    assign enables = st_q.en;
    assign irq     = |(st_q.flg & st_q.en & SRC_MASK);

endmodule

// File: rtl/intr_regbank_plain.sv
module intr_regbank_plain #(
    parameter int N = 7,
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        we,
    input  logic [W-1:0]        wdata,
    output logic [N-1:0][W-1:0] rd
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic [W-1:0] val_d, val_q;

        always_comb begin
            val_d = we[g] ? wdata : val_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end

        assign rd[g] = val_q;
    end

endmodule

// File: rtl/intr_regbank.sv
module intr_regbank
    import intr_regbank_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int IDX_LSB = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              shift_set,
    input  logic              t1_set,
    input  logic [15:0]       t1_count,
    input  logic [15:0]       t1_latch,
    input  logic [15:0]       t2_count,
    input  logic [7:0]        shift_value,
    output logic              irq
);

    localparam int IDX_W = 4;

    reg_idx_e                        reg_idx;
    dec_t                            dec;
    logic [FLAG_W-1:0]               flag_vec;
    logic [FLAG_W-1:0]               en_vec;
    logic [N_PLAIN-1:0][BYTE_W-1:0]  plain_rd;
    logic                            unused_addr;

    assign reg_idx     = reg_idx_e'(bus_addr[IDX_LSB +: IDX_W]);
    assign unused_addr = ^bus_addr;

    intr_regbank_decode u_dec (
        .acc (bus_sel),
        .wr  (bus_we),
        .idx (reg_idx),
        .dec (dec)
    );

    intr_regbank_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_sr  (shift_set),
        .set_t1  (t1_set),
        .flag_we (dec.flag_we),
        .en_we   (dec.en_we),
        .clr_sr  (dec.clr_sr),
        .clr_t1  (dec.clr_t1),
        .wdata   (bus_wdata),
        .flags   (flag_vec),
        .enables (en_vec),
        .irq     (irq)
    );

    intr_regbank_plain #(.N(N_PLAIN), .W(BYTE_W)) u_plain (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (dec.plain_we),
        .wdata (bus_wdata),
        .rd    (plain_rd)
    );

    always_comb begin
        case (reg_idx)
            IX_T1C_LO:  bus_rdata = t1_count[7:0];
            IX_T1C_HI:  bus_rdata = t1_count[15:8];
            IX_T1L_LO:  bus_rdata = t1_latch[7:0];
            IX_T1L_HI:  bus_rdata = t1_latch[15:8];
            IX_T2C_LO:  bus_rdata = t2_count[7:0];
            IX_T2C_HI:  bus_rdata = t2_count[15:8];
            IX_SHIFT:   bus_rdata = shift_value;
            IX_FLAGS:   bus_rdata = {1'b0, flag_vec};
            IX_ENABLES: bus_rdata = {1'b0, en_vec};
            default: begin
                bus_rdata = '0;
                for (int s = 0; s < N_PLAIN; s++) begin
                    if (plain_slot(reg_idx) == s) bus_rdata = plain_rd[s];
                end
            end
        endcase
    end

endmodule

// File: rtl/intr_regbank_chk.sv
module intr_regbank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel,
    input logic       we,
    input logic [3:0] idx,
    input logic [7:0] wdata,
    input logic       shift_set,
    input logic       t1_set,
    input logic [6:0] flags,
    input logic [6:0] enables,
    input logic       irq
);

    logic en_write;
    assign en_write = sel && we && (idx == 4'd14);

    assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_set && !t1_set) |=> ((flags & ~$past(flags)) == 7'h00));

    assert_wr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && we && idx == 4'd13 && wdata[6] && !t1_set) |=> !flags[6]);

    assert_en_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_write && wdata[7]) |=> ((enables & $past(wdata[6:0])) == $past(wdata[6:0])));

    assert_irq_on_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_set && enables[6] && !en_write) |=> irq);

    assert_rd_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !we && idx == 4'd10 && !shift_set) |=> !flags[2]);

    assert_set_wins_sr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        shift_set |=> flags[2]);

    assert_set_wins_t1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        t1_set |=> flags[6]);

endmodule

bind intr_regbank intr_regbank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (bus_sel),
    .we        (bus_we),
    .idx       (reg_idx),
    .wdata     (bus_wdata),
    .shift_set (shift_set),
    .t1_set    (t1_set),
    .flags     (flag_vec),
    .enables   (en_vec),
    .irq       (irq)
);

// File: tb/sim_intr_regbank.sv
`timescale 1ns/1ps
module sim_intr_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        shift_set = 1'b0;
    logic        t1_set = 1'b0;
    logic [15:0] t1_count = 16'h1234;
    logic [15:0] t1_latch = 16'hBEEF;
    logic [15:0] t2_count = 16'h7788;
    logic [7:0]  shift_value = 8'h6D;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    intr_regbank u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .shift_set(shift_set), .t1_set(t1_set), .t1_count(t1_count),
        .t1_latch(t1_latch), .t2_count(t2_count), .shift_value(shift_value),
        .irq(irq)
    );

    // Monitor: compares queued expectations against outputs mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb.pop_front();
                act = it.is_irq ? {7'b0, irq} : bus_rdata;
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
                end
            end
        end
    end

    function automatic logic [15:0] mk_addr(int idx);
        logic [15:0] a;
        a = 16'hE1A5 & ~16'h1E00;
        a[12:9] = idx[3:0];
        return a;
    endfunction

    task automatic op(bit w, int idx, logic [7:0] d, bit ssr, bit st1);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = w; bus_addr = mk_addr(idx);
        bus_wdata = d; shift_set = ssr; t1_set = st1;
    endtask

    task automatic pulse(bit ssr, bit st1);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; shift_set = ssr; t1_set = st1;
    endtask

    task automatic wr(int idx, logic [7:0] d);
        op(1'b1, idx, d, 1'b0, 1'b0);
    endtask

    task automatic rd(int idx, logic [7:0] exp, string tag);
        item_t it;
        op(1'b0, idx, 8'h00, 1'b0, 1'b0);
        it.is_irq = 1'b0; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    // Checks irq in the cycle of the access just issued.
    task automatic chk_irq(bit exp, string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {7'b0, exp}; it.tag = tag;
        sb.push_back(it);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state, R10 bit 7 reads zero
        rd(14, 8'h44, "R8 enables after reset");
        chk_irq(1'b0, "R8 irq low after reset");
        rd(13, 8'h00, "R8 flags after reset");

        // R2 plain storage, R1 index mapping
        rd(0, 8'h00, "R2 port B reset value");
        wr(0, 8'hA5); wr(1, 8'h5A); wr(2, 8'h0F); wr(3, 8'hF0);
        wr(11, 8'h3C); wr(12, 8'hC3); wr(15, 8'h99);
        wr(5, 8'hFF); wr(10, 8'hFF);
        rd(0, 8'hA5, "R2 port B");
        rd(1, 8'h5A, "R2 port A");
        rd(2, 8'h0F, "R2 dir B");
        rd(3, 8'hF0, "R2 dir A");
        rd(11, 8'h3C, "R2 aux control");
        rd(12, 8'hC3, "R2 peripheral control");
        rd(15, 8'h99, "R2 no-handshake port");
        rd(4, 8'h34, "R1 t1 count low");
        rd(5, 8'h12, "R1 t1 count high");
        rd(6, 8'hEF, "R1 t1 latch low");
        rd(7, 8'hBE, "R1 t1 latch high");
        rd(8, 8'h88, "R1 t2 count low");
        rd(9, 8'h77, "R1 t2 count high");
        rd(10, 8'h6D, "R1 shift value");

        // R3 timer-1 strobe, R6 irq, R7 side-effect clears
        pulse(1'b0, 1'b1);
        rd(13, 8'h40, "R3 t1 flag set");
        chk_irq(1'b1, "R6 irq with t1 flag");
        rd(11, 8'h3C, "R7 aux read");
        rd(13, 8'h40, "R7 unrelated read keeps flag");
        rd(4, 8'h34, "R7 count low read");
        rd(13, 8'h00, "R7 count low read clears t1");
        chk_irq(1'b0, "R6 irq drops");
        pulse(1'b0, 1'b1);
        rd(5, 8'h12, "R7 count high read");
        rd(13, 8'h00, "R7 count high read clears t1");
        pulse(1'b1, 1'b0);
        rd(13, 8'h04, "R3 shift flag set");
        chk_irq(1'b1, "R6 irq with shift flag");
        rd(10, 8'h6D, "R7 shift read");
        rd(13, 8'h00, "R7 shift read clears flag");

        // R4 write-one-to-clear
        pulse(1'b1, 1'b1);
        rd(13, 8'h44, "R3 both flags");
        wr(13, 8'h04);
        rd(13, 8'h40, "R4 clear shift only");
        wr(13, 8'hBB);
        rd(13, 8'h40, "R4 zeros keep t1");
        wr(13, 8'h40);
        rd(13, 8'h00, "R4 clear t1");

        // R5 enable set/clear, R6 gating, R10
        wr(14, 8'h04);
        rd(14, 8'h40, "R5 clear-mode write");
        pulse(1'b1, 1'b0);
        rd(13, 8'h04, "R3 shift flag while disabled");
        chk_irq(1'b0, "R6 masked by enable");
        wr(14, 8'hFF);
        rd(14, 8'h7F, "R10 enables bit 7 zero");
        chk_irq(1'b1, "R6 irq after enable");
        wr(13, 8'h04);
        rd(13, 8'h00, "R4 clear shift");
        chk_irq(1'b0, "R6 no flag no irq");
        wr(14, 8'h3B);
        rd(14, 8'h44, "R5 mixed clear");

        // R9 set wins over same-cycle clear
        op(1'b1, 13, 8'h40, 1'b0, 1'b1);
        rd(13, 8'h40, "R9 set beats flag write");
        op(1'b0, 4, 8'h00, 1'b0, 1'b1);
        rd(13, 8'h40, "R9 set beats count read");
        op(1'b0, 10, 8'h00, 1'b1, 1'b0);
        rd(13, 8'h44, "R9 set beats shift read");
        wr(13, 8'hFF);
        rd(13, 8'h00, "R4 clear all");

        pulse(1'b0, 1'b0);
        @(negedge clk);
        #4;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule